// File: doc/BRIEF.md
# Repetitive Pattern Synchronizer

This block locks a received serial bit stream to an arbitrary repeating test pattern held in an on-chip bit memory. Software or a sequencer loads the pattern one bit at a time through a write port and sets the pattern length, anywhere from 1 to `MAX_LEN` bits. The block then hunts for the phase of the incoming stream by moving an alignment pointer through the stored pattern.

Lock is declared only after one whole repetition of the pattern, `length` consecutive valid bits, has matched with no mismatch. While hunting, a mismatching bit slips the alignment and restarts the clean-run count. Once locked, every valid bit is compared with the stored bit at the pointer, and a mismatch raises a one-cycle error pulse that an error counter elsewhere can accumulate. An error-density rule over a sliding window of locked bits drops lock and sends the block back to hunting.

Any change to the pattern memory or the length throws the block back to hunting, so a lock always refers to the pattern currently programmed.

Top module: `rpat_sync_top`

## Requirements
- R1: After reset, `sync_locked`, `bit_err` and `sync_lost` are 0. The length is 1, every pattern bit is 0 and the pointer is at position 0.
- R2: While hunting, a valid bit that differs from the stored bit at the pointer leaves the pointer where it is, which slips the alignment by one bit, and restarts the clean-run count at zero. A matching valid bit advances the pointer by one.
- R3: While hunting, the block locks on the valid bit that completes `length` consecutive matches. `sync_locked` reads 1 from the next clock edge on.
- R4: While locked, each valid bit advances the pointer. Each valid bit that differs from the stored bit raises `bit_err` for exactly one cycle after the edge that takes the bit.
- R5: While locked, when the number of mismatches among the last 64 valid bits (including the current one) reaches 6, the block returns to hunting. At the same edge `sync_lost` pulses for one cycle together with that bit's `bit_err`.
- R6: While locked, 5 or fewer mismatches within any 64 valid bits leave lock in place. The window starts empty each time lock is declared.
- R7: A length write with a value from 1 to 512 takes effect. A length write of 0 or of more than 512 is ignored and does not disturb lock. The pointer wraps from `length-1` to 0.
- R8: A pattern write (`pat_we`=1 writes `pat_wbit` at bit index `pat_waddr`) or an accepted length write forces hunting. It resets the pointer and the clean-run count, does not pulse `sync_lost`, and overrides any data bit presented in the same cycle.
- R9: A cycle with `rx_valid` low and no write changes no state and raises no `bit_err`.
- R10: `bit_err` is never raised for a bit received while hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_we | input | 1 | Pattern memory write strobe |
| pat_waddr | input | 9 | Bit index written |
| pat_wbit | input | 1 | Bit value written |
| len_we | input | 1 | Length write strobe |
| len_wdata | input | 10 | New pattern length, legal range 1..512 |
| rx_valid | input | 1 | Received bit is present this cycle |
| rx_bit | input | 1 | Received data bit |
| sync_locked | output | 1 | Block is locked to the pattern |
| bit_err | output | 1 | One-cycle pulse for a mismatched bit while locked |
| sync_lost | output | 1 | One-cycle pulse when the error-density rule drops lock |

## Verification
Every result of this block is registered once. A write, a data bit or a lock decision presented before a rising edge shows up on `sync_locked`, `bit_err` and `sync_lost` immediately after that edge, and a lock takes exactly `length` clean valid bits from a forced restart when the stream is in phase. The bench drives inputs at the falling edge and advances its behavioural model right after the rising edge that consumes them. It then compares all three outputs at the following falling edge, so each expectation is sampled in the one cycle where that edge makes it valid. The directed checks count bits exactly: a lock that is not yet due after `length-1` bits, a lock at bit `length`, and a slip on a length-2 pattern whose lock time differs from a non-slipping design.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_state_e;

  // next pointer position, wrapping at the programmed length
  function automatic int wrap_next(int pos, int len);
    return (pos + 1 >= len) ? 0 : pos + 1;
  endfunction

  // a length write is accepted only inside 1..maxlen
  function automatic bit len_legal(int len, int maxlen);
    return (len >= 1) && (len <= maxlen);
  endfunction

  // error total of the sliding window after one bit enters and one leaves
  function automatic int window_sum(int cnt, bit enter_err, bit leave_err);
    return cnt + int'(enter_err) - int'(leave_err);
  endfunction

endpackage

// File: rtl/rps_pattern_ram.sv
module rps_pattern_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (we) begin
      bits_q[waddr] <= wbit;
    end
  end

  assign rbit = bits_q[raddr];

endmodule

// File: rtl/rps_align.sv
module rps_align #(
  parameter int MAX_LEN = 512,
  parameter int AW      = 9,
  parameter int LW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          force_hunt,
  input  logic          rx_valid,
  input  logic          mismatch,
  input  logic          drop,
  input  logic [LW-1:0] len_q,
  output logic [AW-1:0] ptr,
  output logic          locked,
  output logic          slip_evt,
  output logic          lock_evt
);

  import rps_pkg::*;

  sync_state_e   state_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_adv;
  logic [LW-1:0] run_q;
  logic [LW-1:0] run_inc;
  logic          take;

  assign take     = rx_valid && !force_hunt;
  assign ptr_adv  = AW'(wrap_next(int'(ptr_q), int'(len_q)));
  assign run_inc  = run_q + 1'b1;
  assign slip_evt = take && (state_q == ST_HUNT) && mismatch;
  assign lock_evt = take && (state_q == ST_HUNT) && !mismatch && (run_inc == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      ptr_q   <= '0;
      run_q   <= '0;
    end else if (force_hunt) begin
      state_q <= ST_HUNT;
      ptr_q   <= '0;
      run_q   <= '0;
    end else if (rx_valid) begin
      case (state_q)
        ST_HUNT: begin
          if (mismatch) begin
            run_q <= '0;
          end else begin
            ptr_q <= ptr_adv;
            if (run_inc == len_q) begin
              state_q <= ST_LOCK;
              run_q   <= '0;
            end else begin
              run_q <= run_inc;
            end
          end
        end
        default: begin
          ptr_q <= ptr_adv;
          if (drop) begin
            state_q <= ST_HUNT;
            run_q   <= '0;
          end
        end
      endcase
    end
  end

  assign ptr    = ptr_q;
  assign locked = (state_q == ST_LOCK);

  AST_SLIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |=> ($stable(ptr_q) && run_q == '0 && !locked)); // R2
  AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(rx_valid) && !$past(mismatch))); // R3
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < int'(len_q)); // R7
  AST_FORCE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    force_hunt |=> (!locked && ptr_q == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !force_hunt) |=> ($stable(ptr_q) && $stable(run_q) && $stable(locked))); // R9

endmodule

// File: rtl/rps_err_window.sv
module rps_err_window #(
  parameter int WIN   = 64,
  parameter int LIMIT = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift,
  input  logic          err,
  output logic          drop,
  output logic [CW-1:0] err_cnt
);

  import rps_pkg::*;

  logic [WIN-1:0] hist_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  cnt_sum;

  assign cnt_sum = CW'(window_sum(int'(cnt_q), err, hist_q[WIN-1]));
  assign drop    = shift && (cnt_sum >= CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (clear || drop) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (shift) begin
      hist_q <= {hist_q[WIN-2:0], err};
      cnt_q  <= cnt_sum;
    end
  end

  assign err_cnt = cnt_q;

  AST_CNT_TRACKS_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) == $countones(hist_q)); // R5
  AST_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < LIMIT); // R6

endmodule

// File: rtl/rpat_sync_top.sv
module rpat_sync_top #(
  parameter int MAX_LEN   = 512,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 6,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pat_we,
  input  logic [AW-1:0] pat_waddr,
  input  logic          pat_wbit,
  input  logic          len_we,
  input  logic [LW-1:0] len_wdata,
  input  logic          rx_valid,
  input  logic          rx_bit,
  output logic          sync_locked,
  output logic          bit_err,
  output logic          sync_lost
);

  import rps_pkg::*;

  logic [LW-1:0] len_q;
  logic          len_ok;
  logic          force_hunt;
  logic [AW-1:0] ptr;
  logic          exp_bit;
  logic          mismatch;
  logic          locked;
  logic          slip_evt;
  logic          lock_evt;
  logic          win_drop;
  logic          win_shift;
  logic          win_clear;
  logic [CW-1:0] win_cnt;
  logic          err_evt;
  logic          err_q;
  logic          lost_q;

  assign len_ok     = len_legal(int'(len_wdata), MAX_LEN);
  assign force_hunt = pat_we || (len_we && len_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= LW'(1);
    end else if (len_we && len_ok) begin
      len_q <= len_wdata;
    end
  end

  rps_pattern_ram #(.DEPTH(MAX_LEN), .AW(AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pat_we),
    .waddr (pat_waddr),
    .wbit  (pat_wbit),
    .raddr (ptr),
    .rbit  (exp_bit)
  );

  assign mismatch = rx_bit ^ exp_bit;

  rps_align #(.MAX_LEN(MAX_LEN), .AW(AW), .LW(LW)) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_hunt (force_hunt),
    .rx_valid   (rx_valid),
    .mismatch   (mismatch),
    .drop       (win_drop),
    .len_q      (len_q),
    .ptr        (ptr),
    .locked     (locked),
    .slip_evt   (slip_evt),
    .lock_evt   (lock_evt)
  );

  assign win_shift = rx_valid && locked && !force_hunt;
  assign win_clear = force_hunt || !locked;
  assign err_evt   = win_shift && mismatch;

  rps_err_window #(.WIN(WIN), .LIMIT(ERR_LIMIT), .CW(CW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (win_clear),
    .shift   (win_shift),
    .err     (mismatch),
    .drop    (win_drop),
    .err_cnt (win_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      err_q  <= err_evt;
      lost_q <= win_drop;
    end
  end

  assign sync_locked = locked;
  assign bit_err     = err_q;
  assign sync_lost   = lost_q;

  AST_ERR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> ($past(rx_valid) && !$past(force_hunt))); // R4
  AST_NO_ERR_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(sync_locked)); // R10
  AST_LOST_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> (!sync_locked && bit_err)); // R5
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(len_q) >= 1) && (int'(len_q) <= MAX_LEN)); // R7
  AST_LOCK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> sync_locked); // R3
  AST_CNT_QUIET_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> (win_cnt == '0)); // R6

endmodule

// File: tb/sim_rpat_sync_top.sv
`timescale 1ns/1ps
module sim_rpat_sync_top;

  localparam int MAX_LEN = 512;
  localparam int WIN     = 64;
  localparam int LIMIT   = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pat_we;
  logic [8:0] pat_waddr;
  logic       pat_wbit;
  logic       len_we;
  logic [9:0] len_wdata;
  logic       rx_valid;
  logic       rx_bit;
  logic       sync_locked;
  logic       bit_err;
  logic       sync_lost;

  always #2.5 clk = ~clk;

  rpat_sync_top u0 (
    .clk(clk), .rst_n(rst_n),
    .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wbit(pat_wbit),
    .len_we(len_we), .len_wdata(len_wdata),
    .rx_valid(rx_valid), .rx_bit(rx_bit),
    .sync_locked(sync_locked), .bit_err(bit_err), .sync_lost(sync_lost)
  );

  // behavioural reference
  bit pat_m [MAX_LEN];
  int len_m;
  int ptr_m;
  int run_m;
  bit lock_m;
  bit prev_lock;
  bit e_err;
  bit e_los;
  int win_q[$];

  int n_chk;
  int n_fail;
  int sidx;
  bit done;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit force_h;
    bit mis;
    int sum;
    prev_lock = lock_m;
    e_err = 1'b0;
    e_los = 1'b0;
    force_h = pat_we || (len_we && len_wdata >= 1 && len_wdata <= MAX_LEN);
    if (force_h) begin
      if (pat_we) pat_m[pat_waddr] = pat_wbit;
      if (len_we && len_wdata >= 1 && len_wdata <= MAX_LEN) len_m = int'(len_wdata);
      lock_m = 1'b0; ptr_m = 0; run_m = 0; win_q.delete();
    end else if (rx_valid) begin
      mis = (rx_bit != pat_m[ptr_m]);
      if (!lock_m) begin
        if (mis) run_m = 0;
        else begin
          ptr_m = (ptr_m + 1) % len_m;
          run_m++;
          if (run_m == len_m) begin lock_m = 1'b1; run_m = 0; win_q.delete(); end
        end
      end else begin
        ptr_m = (ptr_m + 1) % len_m;
        e_err = mis;
        win_q.push_back(int'(mis));
        if (win_q.size() > WIN) void'(win_q.pop_front());
        sum = 0;
        foreach (win_q[k]) sum += win_q[k];
        if (sum >= LIMIT) begin lock_m = 1'b0; e_los = 1'b1; run_m = 0; win_q.delete(); end
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(sync_locked == lock_m, "R3 sync_locked", sync_locked, lock_m);
    chk(bit_err == e_err, "R4 bit_err", bit_err, e_err);
    chk(sync_lost == e_los, "R5 sync_lost", sync_lost, e_los);
    if (!prev_lock) chk(bit_err == 1'b0, "R10 no error while hunting", bit_err, 0);
  endtask

  task automatic wr_pat(int a, bit b);
    pat_we = 1'b1; pat_waddr = 9'(a); pat_wbit = b;
    tick();
    pat_we = 1'b0;
  endtask

  task automatic wr_len(int l);
    len_we = 1'b1; len_wdata = 10'(l);
    tick();
    len_we = 1'b0;
  endtask

  task automatic send_raw(bit v, bit d);
    rx_valid = v; rx_bit = d;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic send(bit v, bit flip);
    rx_valid = v; rx_bit = pat_m[sidx % len_m] ^ flip;
    tick();
    if (v) sidx++;
    rx_valid = 1'b0;
  endtask

  task automatic run_clean(int n);
    repeat (n) send(1'b1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [12:0] p13;
    p13 = 13'b1101000111100;
    n_chk = 0; n_fail = 0; done = 1'b0;
    len_m = 1; ptr_m = 0; run_m = 0; lock_m = 1'b0;
    foreach (pat_m[k]) pat_m[k] = 1'b0;
    rst_n = 1'b0; pat_we = 0; pat_waddr = 0; pat_wbit = 0;
    len_we = 0; len_wdata = 0; rx_valid = 0; rx_bit = 0;
    void'($urandom(11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(sync_locked == 0, "R1 locked after reset", sync_locked, 0);
    chk(bit_err == 0, "R1 bit_err after reset", bit_err, 0);
    chk(sync_lost == 0, "R1 sync_lost after reset", sync_lost, 0);

    // load a 13-bit pattern, aligned stream locks on bit 13
    for (int i = 0; i < 13; i++) wr_pat(i, p13[i]);
    wr_len(13);
    chk(sync_locked == 0, "R8 hunting after writes", sync_locked, 0);
    sidx = 0;
    run_clean(12);
    chk(sync_locked == 0, "R3 not locked after 12 bits", sync_locked, 0);
    run_clean(1);
    chk(sync_locked == 1, "R3 locked after 13 bits", sync_locked, 1);

    // restart, error during hunting, misaligned relock
    wr_len(13);
    sidx = 0;
    run_clean(6);
    send(1'b1, 1'b1);
    run_clean(250);
    chk(sync_locked == 1, "R2 relock after hunting error", sync_locked, 1);

    // five scattered errors keep lock
    repeat (5) begin send(1'b1, 1'b1); run_clean(3); end
    chk(sync_locked == 1, "R6 lock held with 5 errors", sync_locked, 1);
    send(1'b1, 1'b1);
    chk(sync_locked == 0, "R5 lock dropped at 6th error", sync_locked, 0);

    // relock with valid gaps
    repeat (600) send(1'($urandom % 2), 1'b0);
    chk(sync_locked == 1, "R9 relock with valid gaps", sync_locked, 1);
    repeat (20) send(1'b0, 1'b1);
    chk(sync_locked == 1, "R9 idle keeps lock", sync_locked, 1);
    chk(bit_err == 0, "R9 idle raises no error", bit_err, 0);

    // illegal lengths ignored
    wr_len(0);
    wr_len(513);
    chk(sync_locked == 1, "R7 illegal length ignored", sync_locked, 1);
    run_clean(26);
    chk(sync_locked == 1, "R7 pattern still 13 long", sync_locked, 1);

    // length 2 slip case: pattern 1,0 ; stream 0,1,0
    wr_pat(0, 1'b1);
    wr_pat(1, 1'b0);
    wr_len(2);
    send_raw(1'b1, 1'b0);
    send_raw(1'b1, 1'b1);
    chk(sync_locked == 0, "R2 slipped, not yet locked", sync_locked, 0);
    send_raw(1'b1, 1'b0);
    chk(sync_locked == 1, "R2 locked after slip", sync_locked, 1);
    send_raw(1'b1, 1'b0);
    chk(bit_err == 1, "R4 error pulse", bit_err, 1);
    send_raw(1'b0, 1'b0);
    chk(bit_err == 0, "R4 pulse lasts one cycle", bit_err, 0);

    // length 1
    wr_len(1);
    send_raw(1'b1, 1'b1);
    chk(sync_locked == 1, "R7 length 1 locks in one bit", sync_locked, 1);

    // full length 512 with wrap
    for (int i = 0; i < MAX_LEN; i++) wr_pat(i, 1'($urandom % 2));
    wr_len(MAX_LEN);
    sidx = 100;
    run_clean(4000);
    chk(sync_locked == 1, "R7 locked at length 512", sync_locked, 1);

    // write while locked forces hunting without sync_lost
    rx_valid = 1'b1; rx_bit = ~pat_m[sidx % len_m];
    wr_pat(3, ~pat_m[3]);
    rx_valid = 1'b0;
    chk(sync_locked == 0, "R8 write forces hunting", sync_locked, 0);
    chk(sync_lost == 0, "R8 no sync_lost on write", sync_lost, 0);
    chk(bit_err == 0, "R8 data in write cycle ignored", bit_err, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule